// File: doc/BRIEF.md
# Scalable 48-Bit Real-Time Counter

An always-on elapsed-time counter seen by software as four 32-bit registers. A strobe from a slow timebase, nominally 31250 ticks per second, drives a 48-bit stored count. Software reads and writes this count as a 32-bit low word and a 16-bit high word. A power-of-two scale field slows the counter, so that the stored value advances once every 2^scale timebase ticks. The true elapsed tick count is therefore the stored value shifted left by the scale. This keeps long intervals representable in 48 bits at the cost of resolution.

A 32-bit compare register is checked against the top 32 bits of the stored count. When that slice reaches or passes the compare value, a pending flag is raised in the configuration register and on the interrupt output. Reading the low word captures the high word into a shadow register. A following read of the high word therefore belongs to the same 48-bit value, even if the counter carries between the two reads.

The block takes the timebase as a single-cycle strobe in its own clock domain. Generating that strobe, and turning the count into calendar time, are left to the surrounding system.

Top module: `scaled_rtc48`

## Requirements
- R1: After reset the count is 0, enable is 0, scale is 0, compare is 0xFFFFFFFF and irq_o is 0.
- R2: While the enable bit (bit 12 of the configuration register at 0x40) is 0, timebase strobes leave the count unchanged.
- R3: With enable set and scale s in configuration bits [3:0], the stored count increments once every 2^s strobes, on the strobe that completes each group of 2^s.
- R4: A write at 0x48 loads count[31:0]. A write at 0x4C loads count[47:32] from wdata[15:0] and ignores wdata[31:16]. Either write restarts the scale prescaler from zero.
- R5: A read at 0x4C returns zero in bits [31:16]. Its bits [15:0] return count[47:32] as it stood at the most recent read at 0x48.
- R6: The count wraps from 2^48−1 to 0 on its next increment.
- R7: The pending flag (configuration bit 28) and irq_o are 1 exactly while count[47:16] is greater than or equal to the compare register at 0x60.
- R8: A configuration read returns the scale in [3:0], enable in bit 12, pending in bit 28 and zero elsewhere; writes to bit 28 and to the other undefined bits have no effect.
- R9: Reads of an unmapped address return zero and writes to one change no register; rdata_o is zero when rd_en_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Timebase strobe, one cycle per tick |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 8 | Register byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the cycle rd_en_i is high |
| irq_o | output | 1 | Compare-reached interrupt, level |

## Verification
The embedded properties check several behaviours on every cycle:
- the count advances by exactly one on a prescaler step;
- the count holds when there is no step, no write and the enable is clear;
- a high-word write lands only its low 16 bits;
- a word write empties the prescaler;
- a low-word read captures the high word into the shadow;
- the upper half of a high-word read is zero.

Only the bench scenarios can show that each scale value produces the right division ratio over many strobes, and that restarting the prescaler changes when the next step falls. The same holds for the carry from all-ones back to zero, and for the pending level tracking the compare boundary from both sides.

// File: rtl/rtc48_pkg.sv
package rtc48_pkg;
   localparam logic [7:0] OFS_CFG = 8'h40;
   localparam logic [7:0] OFS_LO  = 8'h48;
   localparam logic [7:0] OFS_HI  = 8'h4C;
   localparam logic [7:0] OFS_CMP = 8'h60;
   localparam int         EN_BIT   = 12;
   localparam int         PEND_BIT = 28;
endpackage

// File: rtl/rtc48_prescaler.sv
module rtc48_prescaler #(
   parameter int SCALE_W = 4,
   localparam int PRE_W  = (1 << SCALE_W) - 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick_i,
   input  logic               run_i,
   input  logic               clear_i,
   input  logic [SCALE_W-1:0] scale_i,
   output logic               step_o
);
   logic [PRE_W-1:0] pre_q;
   logic [PRE_W-1:0] mask;

   // a scale of s completes a group when the prescaler holds 2^s - 1
   assign mask   = {PRE_W{1'b1}} >> (PRE_W - int'(scale_i));
   assign step_o = tick_i && run_i && (pre_q >= mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                pre_q <= '0;
      else if (clear_i)          pre_q <= '0;
      else if (step_o)           pre_q <= '0;
      else if (tick_i && run_i)  pre_q <= pre_q + 1'b1;
   end

   // R4
   pre_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> (pre_q == '0));
endmodule

// File: rtl/rtc48_count.sv
module rtc48_count #(
   parameter int CNT_W  = 48,
   parameter int WORD_W = 32,
   localparam int HI_W  = CNT_W - WORD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_i,
   input  logic              wr_lo_i,
   input  logic              wr_hi_i,
   input  logic [WORD_W-1:0] wdata_i,
   output logic [CNT_W-1:0]  count_o
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (wr_lo_i || wr_hi_i) begin
         if (wr_lo_i) cnt_q[WORD_W-1:0]     <= wdata_i;
         if (wr_hi_i) cnt_q[CNT_W-1:WORD_W] <= wdata_i[HI_W-1:0];
      end else if (step_i) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign count_o = cnt_q;

   // R3 R6
   cnt_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !wr_lo_i && !wr_hi_i) |=> (cnt_q == $past(cnt_q) + 1'b1));
   // R2
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!step_i && !wr_lo_i && !wr_hi_i) |=> $stable(cnt_q));
   // R4
   cnt_hiwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hi_i |=> (cnt_q[CNT_W-1:WORD_W] == $past(wdata_i[HI_W-1:0])));
endmodule

// File: rtl/scaled_rtc48.sv
module scaled_rtc48 import rtc48_pkg::*; #(
   parameter int ADDR_W  = 8,
   parameter int WORD_W  = 32,
   parameter int CNT_W   = 48,
   parameter int SCALE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              wr_en_i,
   input  logic              rd_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [WORD_W-1:0] wdata_i,
   output logic [WORD_W-1:0] rdata_o,
   output logic              irq_o
);
   localparam int HI_W = CNT_W - WORD_W;

   generate
      if (CNT_W <= WORD_W || CNT_W > 2 * WORD_W)
         $error("CNT_W must lie between WORD_W+1 and 2*WORD_W");
      if (SCALE_W < 1 || SCALE_W > 4)
         $error("SCALE_W must lie between 1 and 4");
      if (PEND_BIT >= WORD_W || EN_BIT < SCALE_W)
         $error("configuration fields do not fit the word");
      if (ADDR_W < 8)
         $error("ADDR_W too narrow for the register offsets");
   endgenerate

   logic               sel_cfg, sel_lo, sel_hi, sel_cmp;
   logic               en_q;
   logic [SCALE_W-1:0] scale_q;
   logic [WORD_W-1:0]  cmp_q;
   logic [HI_W-1:0]    shadow_q;
   logic [CNT_W-1:0]   count;
   logic               step, wr_lo, wr_hi, pending;
   logic [WORD_W-1:0]  rd_mux;

   assign sel_cfg = (addr_i == ADDR_W'(OFS_CFG));
   assign sel_lo  = (addr_i == ADDR_W'(OFS_LO));
   assign sel_hi  = (addr_i == ADDR_W'(OFS_HI));
   assign sel_cmp = (addr_i == ADDR_W'(OFS_CMP));
   assign wr_lo   = wr_en_i && sel_lo;
   assign wr_hi   = wr_en_i && sel_hi;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q     <= 1'b0;
         scale_q  <= '0;
         cmp_q    <= '1;
         shadow_q <= '0;
      end else begin
         if (wr_en_i && sel_cfg) begin
            en_q    <= wdata_i[EN_BIT];
            scale_q <= wdata_i[SCALE_W-1:0];
         end
         if (wr_en_i && sel_cmp) cmp_q <= wdata_i;
         if (rd_en_i && sel_lo)  shadow_q <= count[CNT_W-1:WORD_W];
      end
   end

   rtc48_prescaler #(.SCALE_W(SCALE_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .run_i(en_q),
      .clear_i(wr_lo || wr_hi), .scale_i(scale_q), .step_o(step));

   rtc48_count #(.CNT_W(CNT_W), .WORD_W(WORD_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .step_i(step), .wr_lo_i(wr_lo),
      .wr_hi_i(wr_hi), .wdata_i(wdata_i), .count_o(count));

   assign pending = (count[CNT_W-1:CNT_W-WORD_W] >= cmp_q);
   assign irq_o   = pending;

   always_comb begin
      rd_mux = '0;
      if (sel_cfg) begin
         rd_mux[SCALE_W-1:0] = scale_q;
         rd_mux[EN_BIT]      = en_q;
         rd_mux[PEND_BIT]    = pending;
      end else if (sel_lo) begin
         rd_mux = count[WORD_W-1:0];
      end else if (sel_hi) begin
         rd_mux[HI_W-1:0] = shadow_q;
      end else if (sel_cmp) begin
         rd_mux = cmp_q;
      end
   end

   assign rdata_o = rd_en_i ? rd_mux : '0;

   // R2
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q && !wr_lo && !wr_hi) |=> $stable(count));
   // R5
   shadow_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en_i && sel_lo) |=> (shadow_q == $past(count[CNT_W-1:WORD_W])));
   // R5
   hi_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en_i && sel_hi) |-> (rdata_o[WORD_W-1:HI_W] == '0));
endmodule

// File: tb/scaled_rtc48_test.sv
module scaled_rtc48_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_i = 1'b0, wr_en_i = 1'b0, rd_en_i = 1'b0;
   logic [7:0]  addr_i = '0;
   logic [31:0] wdata_i = '0;
   logic [31:0] rdata_o;
   logic        irq_o;
   int total = 0, bad = 0;

   always #2 clk = ~clk;

   scaled_rtc48 uut (.clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
      .rd_en_i(rd_en_i), .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
      .irq_o(irq_o));

   localparam int NV = 7;
   localparam int V_SCALE[NV] = '{0, 1, 2, 3, 0, 4, 15};
   localparam int V_EN[NV]    = '{1, 1, 1, 1, 0, 1, 1};
   localparam int V_TICKS[NV] = '{10, 10, 11, 16, 20, 47, 32768};
   localparam int V_EXP[NV]   = '{10, 5, 2, 2, 0, 2, 1};

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk); wr_en_i = 1'b1; addr_i = a; wdata_i = d;
      @(negedge clk); wr_en_i = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk); rd_en_i = 1'b1; addr_i = a;
      #1 d = rdata_o;
      @(negedge clk); rd_en_i = 1'b0;
   endtask

   task automatic ticks(input int n);
      @(negedge clk); tick_i = 1'b1;
      repeat (n) @(negedge clk);
      tick_i = 1'b0;
   endtask

   initial begin
      #(4 * 150000);
      bad++;
      $display("FAIL watchdog got=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      check("R1 irq", {31'b0, irq_o}, 32'h0);
      rd(8'h40, v); check("R1 cfg", v, 32'h0);
      rd(8'h48, v); check("R1 lo", v, 32'h0);
      rd(8'h4C, v); check("R1 hi", v, 32'h0);
      rd(8'h60, v); check("R1 cmp", v, 32'hFFFF_FFFF);
      // R9 idle read bus
      #1 check("R9 idle rdata", rdata_o, 32'h0);

      // R2 R3 table walk
      for (int i = 0; i < NV; i++) begin
         wr(8'h40, 32'h0);
         wr(8'h48, 32'h0);
         wr(8'h4C, 32'h0);
         wr(8'h40, (V_EN[i] << 12) | V_SCALE[i]);
         ticks(V_TICKS[i]);
         rd(8'h48, v);
         check(V_EN[i] ? "R3 scaled count" : "R2 disabled hold", v, V_EXP[i]);
      end

      // R4 prescaler restart on count write
      wr(8'h40, 32'h0000_1002);
      wr(8'h48, 32'h0);
      ticks(3);
      wr(8'h48, 32'h0);
      ticks(1);
      rd(8'h48, v); check("R4 restart", v, 32'h0);
      ticks(3);
      rd(8'h48, v); check("R4 after restart", v, 32'h1);

      // R4 R5 high word ignores upper bits, shadow via low read
      wr(8'h40, 32'h0);
      wr(8'h4C, 32'hABCD_1234);
      rd(8'h48, v);
      rd(8'h4C, v); check("R5 hi shadow", v, 32'h0000_1234);
      wr(8'h4C, 32'h0000_0055);
      rd(8'h4C, v); check("R5 hi stale until lo read", v, 32'h0000_1234);

      // R6 R7 wrap from all ones, pending at reset compare
      wr(8'h48, 32'hFFFF_FFFF);
      wr(8'h4C, 32'h0000_FFFF);
      #1 check("R7 irq at max", {31'b0, irq_o}, 32'h1);
      rd(8'h40, v); check("R7 cfg pending", v, 32'h1000_0000);
      wr(8'h40, 32'h0000_1000);
      ticks(1);
      rd(8'h48, v); check("R6 wrap lo", v, 32'h0);
      rd(8'h4C, v); check("R6 wrap hi", v, 32'h0);
      #1 check("R7 irq after wrap", {31'b0, irq_o}, 32'h0);

      // R7 compare boundary
      wr(8'h40, 32'h0);
      wr(8'h60, 32'h0001_0000);
      wr(8'h48, 32'h0);
      wr(8'h4C, 32'h0000_0001);
      #1 check("R7 equal", {31'b0, irq_o}, 32'h1);
      wr(8'h60, 32'h0001_0001);
      #1 check("R7 below", {31'b0, irq_o}, 32'h0);
      wr(8'h48, 32'h0001_0000);
      #1 check("R7 reached", {31'b0, irq_o}, 32'h1);

      // R8 config write of all ones keeps defined fields only
      wr(8'h60, 32'hFFFF_FFFF);
      wr(8'h40, 32'hFFFF_FFFF);
      rd(8'h40, v); check("R8 cfg mask", v, 32'h0000_100F);
      wr(8'h40, 32'h1000_0000);
      rd(8'h40, v); check("R8 pending not writable", v, 32'h0);

      // R9 unmapped address
      wr(8'h44, 32'hDEAD_BEEF);
      rd(8'h44, v); check("R9 unmapped read", v, 32'h0);
      rd(8'h48, v); check("R9 lo untouched", v, 32'h0001_0000);
      rd(8'h60, v); check("R9 cmp untouched", v, 32'hFFFF_FFFF);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule